// File: doc/BRIEF.md
# System-Control Coprocessor Register Access Unit

This block sits beside a processor core and services the core's register-transfer instructions to the system-control coprocessor (number 15). Each cycle the core may present one 32-bit coprocessor instruction word with a valid strobe, a flag saying whether it runs in a privileged mode, and the data of the core register being transferred. The block classifies the word. A privileged transfer is accepted, and an illegal one raises an undefined-instruction trap. Words aimed at any other coprocessor, and words that are not coprocessor instructions, are left alone.

An accepted read returns one of three things, chosen by the register number field and the secondary opcode field. Register 0 returns a device identification word or a cache type word. Registers 1 to 15 each return the last value written to them. An accepted write stores the full 32-bit value in the named holding register. Register 0 cannot be written. Every response comes one cycle after the strobe, as a single-cycle read-valid pulse or a single-cycle trap pulse.

Top module: `cop_regacc`

## Requirements
- R1: In the first cycle after reset, `rd_valid` and `trap` are low. Holding registers 1 to 15 read back as 0 until they are written.
- R2: The block accepts a read in this case: a valid word with bits 27:24 = 4'b1110, bit 4 = 1, bit 20 (direction) = 1 and bits 11:8 = 15, with `priv_mode` = 1. In the cycle after the strobe, `rd_valid` is high for exactly one cycle and `trap` is low.
- R3: An accepted read with register field bits 19:16 = 0 and secondary opcode bits 7:5 other than 1 returns the identification word. Its fields are {8'h41, 4'h1, 4'h2, 12'h920, LAYOUT_REV}, from bit 31 down to bit 0.
- R4: An accepted read with bits 19:16 = 0 and bits 7:5 = 1 returns the parameter CACHE_TYPE unchanged.
- R5: An accepted write (bit 20 = 0) to register 1 to 15 stores `wr_data`. A later accepted read of the same register returns that value. A write raises neither `rd_valid` nor `trap`.
- R6: An accepted write to register 0 changes no holding register.
- R7: A register transfer to coprocessor 15 with `priv_mode` = 0 raises `trap` for one cycle in the cycle after the strobe. It raises no `rd_valid`, and if it is a write it stores nothing.
- R8: Two other instruction kinds aimed at coprocessor 15 also raise `trap`, whatever the value of `priv_mode`. One is the data-processing form: bits 27:24 = 4'b1110 and bit 4 = 0. The other is the load/store form: bits 27:25 = 3'b110.
- R9: Words whose bits 11:8 are not 15, and words of neither coprocessor form, produce no `rd_valid` and no `trap` and change no holding register.
- R10: `rd_valid` and `trap` are never high together. Neither is high in a cycle that follows a cycle without `instr_valid`.
- R11: The condition field (bits 31:28) and the core-register field (bits 15:12) do not affect the response or the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr_word | input | 32 | Coprocessor instruction word |
| priv_mode | input | 1 | Core is in a privileged mode |
| wr_data | input | 32 | Core register value for a write transfer |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds read data |
| rd_data | output | 32 | Read data |
| trap | output | 1 | One-cycle undefined-instruction trap pulse |

## Verification
The assertions assume that the core presents at most one instruction per cycle. They also assume that `priv_mode` and `wr_data` are steady while `instr_valid` is high. The bench keeps within this: it drives every word for exactly one cycle, changing inputs only on the falling clock edge, and drops the strobe between words. The bench sweeps both privilege levels, all eight secondary opcodes on register 0, every holding register and every foreign coprocessor number. It also varies the condition and core-register fields so that their values cannot affect the outcome.

// File: rtl/cop_pkg.sv
// Package: shared types for the coprocessor register access unit.
// Assumes a 32-bit instruction word with the field layout used by cop_decode.
package cop_pkg;
    typedef enum logic [1:0] {
        CLS_NONE     = 2'd0,
        CLS_XFER     = 2'd1,
        CLS_DATAPROC = 2'd2,
        CLS_LDST     = 2'd3
    } cop_cls_t;

    typedef struct packed {
        cop_cls_t   cls;
        logic       is_read;
        logic [3:0] crn;
        logic [3:0] cpnum;
        logic [2:0] op2;
    } cop_dec_t;
endpackage

// File: rtl/cop_decode.sv
// Module: cop_decode
// Splits a coprocessor instruction word into its fields and classifies it.
// It then produces the accept-read, accept-write and trap requests.
// Assumes a purely combinational use; the caller registers the results.
module cop_decode
    import cop_pkg::*;
#(
    parameter logic [3:0] CP_NUM = 4'd15
) (
    input  logic [31:0] word,
    input  logic        priv,
    output cop_dec_t    dec,
    output logic        acc_rd,
    output logic        acc_wr,
    output logic        trap_req
);
    logic hit;

    // Field extraction and instruction class.
    always_comb begin
        dec.is_read = word[20];
        dec.crn     = word[19:16];
        dec.cpnum   = word[11:8];
        dec.op2     = word[7:5];
        if (word[27:24] == 4'b1110)
            dec.cls = word[4] ? CLS_XFER : CLS_DATAPROC;
        else if (word[27:25] == 3'b110)
            dec.cls = CLS_LDST;
        else
            dec.cls = CLS_NONE;
    end

    // Acceptance and trap decisions for words aimed at this coprocessor.
    always_comb begin
        hit      = (dec.cpnum == CP_NUM) && (dec.cls != CLS_NONE);
        acc_rd   = hit && (dec.cls == CLS_XFER) && priv && dec.is_read;
        acc_wr   = hit && (dec.cls == CLS_XFER) && priv && !dec.is_read;
        trap_req = hit && ((dec.cls != CLS_XFER) || !priv);
    end
endmodule

// File: rtl/cop_idregs.sv
// Module: cop_idregs
// Read view of register 0: cache type word for secondary opcode 1, otherwise
// the identification word. Assumes the caller only uses it for register 0.
module cop_idregs #(
    parameter logic [3:0]  LAYOUT_REV = 4'h0,
    parameter logic [31:0] CACHE_TYPE = 32'h0
) (
    input  logic [2:0]  op2,
    output logic [31:0] word
);
    localparam logic [7:0]  IMPL_CODE = 8'h41;
    localparam logic [3:0]  SPEC_REV  = 4'h1;
    localparam logic [3:0]  ARCH_CODE = 4'h2;
    localparam logic [11:0] PART_NUM  = 12'h920;
    localparam logic [31:0] ID_WORD   = {IMPL_CODE, SPEC_REV, ARCH_CODE, PART_NUM, LAYOUT_REV};

    // Choose between the two register-0 views.
    always_comb begin
        word = (op2 == 3'd1) ? CACHE_TYPE : ID_WORD;
    end
endmodule

// File: rtl/cop_ctrlbank.sv
// Module: cop_ctrlbank
// Plain storage for control registers 1..NUM_CTRL, each DATA_W bits wide.
// Assumes wr_en is only raised for accepted writes; register 0 has no storage.
module cop_ctrlbank #(
    parameter int DATA_W = 32,
    parameter int SEL_W  = 4,
    localparam int NUM_CTRL = (1 << SEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] hold_q [1:NUM_CTRL];

    for (genvar gi = 1; gi <= NUM_CTRL; gi++) begin : g_reg
        // Load one holding register on a write that names it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_q[gi] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(gi)))
                hold_q[gi] <= wr_val;
        end

        // R6, R7, R9: a register changes only through a write naming it.
        p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_sel == SEL_W'(gi))) |=> $stable(hold_q[gi]));
    end

    // Read multiplexer; register 0 has no storage and reads as zero here.
    always_comb begin
        rd_val = '0;
        for (int i = 1; i <= NUM_CTRL; i++)
            if (rd_sel == SEL_W'(i))
                rd_val = hold_q[i];
    end
endmodule

// File: rtl/cop_regacc.sv
// Module: cop_regacc (top)
// Front end for register transfers to the system-control coprocessor.
// It decodes each strobed word, then answers one cycle later with a read-valid
// pulse or a trap pulse; accepted writes return no pulse.
// Assumes at most one instruction per cycle; condition codes are handled upstream.
module cop_regacc
    import cop_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter logic [3:0]  CP_NUM     = 4'd15,
    parameter logic [3:0]  LAYOUT_REV = 4'h0,
    parameter logic [31:0] CACHE_TYPE = 32'h0D172172
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic              priv_mode,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              trap
);
    localparam int SEL_W = 4;

    cop_dec_t          dec;
    logic              acc_rd, acc_wr, trap_req;
    logic [31:0]       id_word;
    logic [DATA_W-1:0] bank_val;
    logic [DATA_W-1:0] rd_mux;

    cop_decode #(.CP_NUM(CP_NUM)) u_decode (
        .word     (instr_word),
        .priv     (priv_mode),
        .dec      (dec),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .trap_req (trap_req)
    );

    cop_idregs #(.LAYOUT_REV(LAYOUT_REV), .CACHE_TYPE(CACHE_TYPE)) u_idregs (
        .op2  (dec.op2),
        .word (id_word)
    );

    cop_ctrlbank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (instr_valid && acc_wr),
        .wr_sel (dec.crn),
        .wr_val (wr_data),
        .rd_sel (dec.crn),
        .rd_val (bank_val)
    );

    // Pick register-0 views or a holding register for the read path.
    always_comb begin
        rd_mux = (dec.crn == '0) ? DATA_W'(id_word) : bank_val;
    end

    // Register the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            trap     <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= instr_valid && acc_rd;
            trap     <= instr_valid && trap_req;
            if (instr_valid && acc_rd)
                rd_data <= rd_mux;
        end
    end

    // R10: never both pulses.
    p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && trap));

    // R10: no response without a strobe.
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!rd_valid && !trap));

    // R7: unprivileged transfer to this coprocessor traps.
    p_unpriv_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !priv_mode && instr_word[27:24] == 4'b1110 && instr_word[4]
         && instr_word[11:8] == CP_NUM) |=> (trap && !rd_valid));

    // R8: load/store form to this coprocessor traps.
    p_ldst_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr_word[27:25] == 3'b110 && instr_word[11:8] == CP_NUM)
        |=> trap);

    // R3: identification word on register 0, secondary opcode other than 1.
    p_id_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && priv_mode && instr_word[27:24] == 4'b1110 && instr_word[4]
         && instr_word[20] && instr_word[11:8] == CP_NUM && instr_word[19:16] == 4'd0
         && instr_word[7:5] != 3'd1)
        |=> (rd_valid && rd_data == DATA_W'({8'h41, 4'h1, 4'h2, 12'h920, LAYOUT_REV})));

    // R4: cache type word on register 0, secondary opcode 1.
    p_cache_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && priv_mode && instr_word[27:24] == 4'b1110 && instr_word[4]
         && instr_word[20] && instr_word[11:8] == CP_NUM && instr_word[19:16] == 4'd0
         && instr_word[7:5] == 3'd1)
        |=> (rd_valid && rd_data == DATA_W'(CACHE_TYPE)));
endmodule

// File: tb/cop_regacc_tb.sv
module cop_regacc_tb;
    localparam logic [3:0]  T_LAYOUT = 4'h3;
    localparam logic [31:0] T_CACHE  = 32'h0D172172;
    localparam logic [31:0] T_ID     = {8'h41, 4'h1, 4'h2, 12'h920, T_LAYOUT};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        priv_mode = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_valid, trap;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] shadow [1:15];

    always #2 clk = ~clk;

    cop_regacc #(.LAYOUT_REV(T_LAYOUT), .CACHE_TYPE(T_CACHE)) u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .priv_mode(priv_mode), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .trap(trap)
    );

    function automatic logic [31:0] xfer(input logic [3:0] cond, input logic rd,
            input logic [3:0] crn, input logic [3:0] rdreg, input logic [3:0] cp,
            input logic [2:0] op2);
        return {cond, 4'b1110, 3'b000, rd, crn, rdreg, cp, op2, 1'b1, 4'b0000};
    endfunction

    function automatic logic [31:0] pat(input int i, input int k);
        return 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'(k * 7919);
    endfunction

    // Present one word for one cycle, then compare the response.
    task automatic run(input logic [31:0] w, input logic pv, input logic [31:0] wd,
                       input logic ev, input logic et, input logic [31:0] ed,
                       input string tag);
        @(negedge clk);
        instr_word = w; priv_mode = pv; wr_data = wd; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        n_chk++;
        if (rd_valid !== ev || trap !== et || (ev && rd_data !== ed)) begin
            n_fail++;
            $display("FAIL %s word=%h: valid=%b trap=%b data=%h expected valid=%b trap=%b data=%h",
                     tag, w, rd_valid, trap, rd_data, ev, et, ed);
        end
    endtask

    // Read every holding register back against the shadow copy.
    task automatic read_all(input string tag);
        for (int r = 1; r <= 15; r++)
            run(xfer(4'hE, 1'b1, 4'(r), 4'd1, 4'd15, 3'd0), 1'b1, 32'h0,
                1'b1, 1'b0, shadow[r], tag);
    endtask

    initial begin
        for (int r = 1; r <= 15; r++) shadow[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rd_valid !== 1'b0 || trap !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset outputs valid=%b trap=%b expected 0 0", rd_valid, trap);
        end
        read_all("R1 reset value");

        // R2 R3 R4 R11: register-0 views over every secondary opcode and field mixes.
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 16; c += 5)
                run(xfer(4'(c), 1'b1, 4'd0, 4'(o + c), 4'd15, 3'(o)), 1'b1, 32'hFFFF_FFFF,
                    1'b1, 1'b0, (o == 1) ? T_CACHE : T_ID,
                    (o == 1) ? "R4 cache type R2" : "R3 id word R2 R11");

        // R5: write every holding register, then read back.
        for (int k = 0; k < 3; k++) begin
            for (int r = 1; r <= 15; r++) begin
                run(xfer(4'(r), 1'b0, 4'(r), 4'(k), 4'd15, 3'(k)), 1'b1, pat(r, k),
                    1'b0, 1'b0, 32'h0, "R5 write no pulse");
                shadow[r] = pat(r, k);
            end
            read_all("R5 readback");
        end

        // R6: writes to register 0 change nothing.
        for (int o = 0; o < 8; o++)
            run(xfer(4'hE, 1'b0, 4'd0, 4'd2, 4'd15, 3'(o)), 1'b1, 32'hDEAD_BEEF,
                1'b0, 1'b0, 32'h0, "R6 reg0 write");
        read_all("R6 state kept");

        // R7: unprivileged transfers trap and store nothing.
        for (int r = 0; r <= 15; r++) begin
            run(xfer(4'hE, 1'b0, 4'(r), 4'd3, 4'd15, 3'd0), 1'b0, 32'h1234_5678,
                1'b0, 1'b1, 32'h0, "R7 unpriv write");
            run(xfer(4'hE, 1'b1, 4'(r), 4'd3, 4'd15, 3'd1), 1'b0, 32'h0,
                1'b0, 1'b1, 32'h0, "R7 unpriv read");
        end
        read_all("R7 state kept");

        // R8: data-processing and load/store forms trap at both privilege levels.
        for (int p = 0; p < 2; p++) begin
            run({4'hE, 4'b1110, 4'h0, 4'h1, 4'h2, 4'd15, 3'd0, 1'b0, 4'h0}, p[0], 32'h0,
                1'b0, 1'b1, 32'h0, "R8 data-processing");
            run({4'hE, 3'b110, 5'b11000, 4'h1, 4'h2, 4'd15, 8'h04}, p[0], 32'h0,
                1'b0, 1'b1, 32'h0, "R8 store");
            run({4'hE, 3'b110, 5'b11001, 4'h1, 4'h2, 4'd15, 8'h04}, p[0], 32'h0,
                1'b0, 1'b1, 32'h0, "R8 load");
        end

        // R9: other coprocessor numbers and non-coprocessor words are ignored.
        for (int cp = 0; cp < 15; cp++) begin
            run(xfer(4'hE, 1'b0, 4'd4, 4'd0, 4'(cp), 3'd0), 1'b1, 32'h0BAD_0BAD,
                1'b0, 1'b0, 32'h0, "R9 foreign write");
            run(xfer(4'hE, 1'b1, 4'd0, 4'd0, 4'(cp), 3'd0), 1'b0, 32'h0,
                1'b0, 1'b0, 32'h0, "R9 foreign read");
            run({4'hE, 4'b1110, 8'h00, 4'(cp), 8'h00}, 1'b0, 32'h0,
                1'b0, 1'b0, 32'h0, "R9 foreign data-processing");
        end
        run({4'hE, 4'b0000, 12'h040, 4'd15, 8'h10}, 1'b1, 32'h0BAD_0BAD,
            1'b0, 1'b0, 32'h0, "R9 non-coprocessor");
        read_all("R9 state kept");

        // R10: no response in idle cycles.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_chk++;
            if (rd_valid !== 1'b0 || trap !== 1'b0) begin
                n_fail++;
                $display("FAIL R10 idle valid=%b trap=%b expected 0 0", rd_valid, trap);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule